// File: doc/BRIEF.md
# Masked Crate Busy Combiner

This block forms a single crate-level busy indication from the busy lines of up to sixteen readout boards sitting in backplane slots. Each slot line is active low, so a slot with no board (whose line idles high) reads as not busy. Every slot can be excluded under register control through its own mask bit. The surviving slot busies are ORed together, and this slot term is merged with a front-panel external busy term (two inputs) and an internal busy term (signal deadtime, burst busy and a software test bit). Each of the three terms has its own enable.

A stand-alone mode input forces the crate busy on regardless of any source. The crate busy output is registered. It feeds both the backplane and the front panel. A per-slot status word and a source status word are provided for a register block to read. Two front-panel indicator drives, one for slot busy and one for module busy, are stretched by a counter so that even a single-cycle busy is visible for a human-scale time (60 ms by default, derived from the clock frequency).

Slot lines and external busy lines are asynchronous and pass through two-flop synchronisers. Control bits and internal sources are assumed synchronous to the block clock.

Top module: `crate_busy_combiner`

## Requirements
- R1: A slot input at logic 1 means not busy. `status_slot_o[i]` is 1 exactly when slot input i was 0, reflecting the input as sampled two rising edges earlier. After reset all slots read not busy.
- R2: A `slot_mask` bit of 1 removes that slot from the crate busy and from `status_src_o[0]`. The mask has no effect on `status_slot_o`.
- R3: The masked slot OR drives `busy_o` only while `en_slot` is 1.
- R4: The external term (`ext_busy_nim` OR `ext_busy_ecl`, both active high) drives `busy_o` only while `en_ext` is 1.
- R5: The internal term (`int_deadtime` OR `int_burst` OR `test_busy`) drives `busy_o` only while `en_int` is 1.
- R6: `standalone` at 1 forces `busy_o` to 1 after the next rising edge, whatever the sources and enables.
- R7: A change on a slot or external input reaches `busy_o` after the third rising edge. A change on an enable, mask, internal source, test bit or `standalone` reaches it after the first rising edge.
- R8: `status_src_o` layout: bit 0 is the masked slot OR, bit 1 the external OR, bit 2 is `int_deadtime` OR `int_burst`, bit 3 is `test_busy`, and bit 4 equals `busy_o`. Bits 0 to 3 are taken before the enables and are updated on the same edge as `busy_o`.
- R9: `led_module_o` rises one cycle after `busy_o` rises. It stays high for (busy high cycles + N - 1) cycles, where N = CLK_HZ/1000*STRETCH_MS.
- R10: `led_slot_o` follows `status_src_o[0]` by the same rule as R9.
- R11: During and right after synchronous active-low reset, `busy_o`, both status words and both indicator drives are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_busy_n | input | N_SLOTS | Per-slot busy lines, active low, asynchronous |
| slot_mask | input | N_SLOTS | 1 excludes the slot from the crate busy |
| en_slot | input | 1 | Enables the slot busy term |
| en_ext | input | 1 | Enables the external busy term |
| en_int | input | 1 | Enables the internal and test busy term |
| ext_busy_nim | input | 1 | Front-panel external busy, active high, asynchronous |
| ext_busy_ecl | input | 1 | Second front-panel external busy, active high, asynchronous |
| int_deadtime | input | 1 | Internal deadtime busy, synchronous |
| int_burst | input | 1 | Internal burst busy, synchronous |
| test_busy | input | 1 | Software test busy bit |
| standalone | input | 1 | Stand-alone mode, forces busy |
| busy_o | output | 1 | Registered crate busy to backplane and front panel |
| status_slot_o | output | N_SLOTS | Synchronised per-slot busy, active high, unmasked |
| status_src_o | output | 5 | Source status word, layout in R8 |
| led_slot_o | output | 1 | Stretched slot-busy indicator drive |
| led_module_o | output | 1 | Stretched module-busy indicator drive |

## Verification
On every cycle the assertions check several behaviours. Stand-alone mode forces busy. With every term disabled and stand-alone off, busy stays low. An enabled test busy gives busy on the next cycle. Each indicator drive is on in the cycle after its trigger. Only the bench's scenarios can show the rest. This covers the exact three-edge latency of the synchronised paths, that masks hide a slot from the crate busy but not from the slot status, and the precise stretch length of the indicators. The bench shows these by comparing every cycle against a latency-accurate reference and by measuring pulse lengths.

// File: rtl/busy_pkg.sv
// busy_pkg: shared constants for the crate busy combiner.
// Assumes nothing beyond integer parameter arithmetic.
package busy_pkg;
    localparam int SRC_W    = 5;
    localparam int SRC_SLOT = 0;
    localparam int SRC_EXT  = 1;
    localparam int SRC_INT  = 2;
    localparam int SRC_TEST = 3;
    localparam int SRC_OUT  = 4;

    // Number of clock cycles in a stretch window of ms milliseconds
    function automatic int stretch_cycles(input int clk_hz, input int ms);
        return (clk_hz / 1000) * ms;
    endfunction
endpackage

// File: rtl/busy_sync.sv
// busy_sync: two-flop synchroniser for a vector of asynchronous levels.
// Assumes each bit is an independent level; no bus coherency is implied.
// RST_VAL selects the idle value loaded by reset (all ones for active-low lines).
module busy_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Two-stage capture of the asynchronous levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/busy_merge.sv
// busy_merge: masks slot busies, merges the enabled terms and registers
// the crate busy together with the source status word.
// Assumes all inputs are synchronous to clk (slot/ext already synchronised).
module busy_merge
    import busy_pkg::*;
#(
    parameter int N_SLOTS = 16,
    parameter int N_EXT   = 2,
    parameter int N_INT   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SLOTS-1:0] slot_busy,
    input  logic [N_SLOTS-1:0] slot_mask,
    input  logic [N_EXT-1:0]   ext_busy,
    input  logic [N_INT-1:0]   int_busy,
    input  logic               test_busy,
    input  logic               en_slot,
    input  logic               en_ext,
    input  logic               en_int,
    input  logic               standalone,
    output logic               busy_o,
    output logic [SRC_W-1:0]   status_src_o
);
    logic slot_any;
    logic ext_any;
    logic int_any;
    logic busy_next;
    logic [SRC_W-1:0] src_next;

    // Reduce each source group and combine under the enables
    always_comb begin
        slot_any  = |(slot_busy & ~slot_mask);
        ext_any   = |ext_busy;
        int_any   = |int_busy;
        busy_next = (en_slot & slot_any)
                  | (en_ext  & ext_any)
                  | (en_int  & (int_any | test_busy))
                  | standalone;
        src_next           = '0;
        src_next[SRC_SLOT] = slot_any;
        src_next[SRC_EXT]  = ext_any;
        src_next[SRC_INT]  = int_any;
        src_next[SRC_TEST] = test_busy;
        src_next[SRC_OUT]  = busy_next;
    end

    // Output register for the crate busy and the status word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o       <= 1'b0;
            status_src_o <= '0;
        end else begin
            busy_o       <= busy_next;
            status_src_o <= src_next;
        end
    end
endmodule

// File: rtl/vis_stretch.sv
// vis_stretch: keeps an indicator on for N cycles after the last active
// trigger cycle; the counter reloads on every active trigger cycle.
// Assumes trig is synchronous and N >= 1.
module vis_stretch #(
    parameter int N     = 10,
    parameter int CNT_W = $clog2(N + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic led_o
);
    logic [CNT_W-1:0] cnt_q;

    // Reload on trigger, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (trig) begin
            cnt_q <= CNT_W'(N);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign led_o = (cnt_q != '0);
endmodule

// File: rtl/crate_busy_combiner.sv
// crate_busy_combiner: crate-level busy from masked slot busies, external
// and internal busies, with stand-alone forcing and stretched indicators.
// Assumes slot and external inputs are asynchronous; everything else is
// synchronous to clk. Reset is synchronous and active low.
module crate_busy_combiner
    import busy_pkg::*;
#(
    parameter int N_SLOTS    = 16,
    parameter int CLK_HZ     = 100_000_000,
    parameter int STRETCH_MS = 60
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SLOTS-1:0] slot_busy_n,
    input  logic [N_SLOTS-1:0] slot_mask,
    input  logic               en_slot,
    input  logic               en_ext,
    input  logic               en_int,
    input  logic               ext_busy_nim,
    input  logic               ext_busy_ecl,
    input  logic               int_deadtime,
    input  logic               int_burst,
    input  logic               test_busy,
    input  logic               standalone,
    output logic               busy_o,
    output logic [N_SLOTS-1:0] status_slot_o,
    output logic [SRC_W-1:0]   status_src_o,
    output logic               led_slot_o,
    output logic               led_module_o
);
    localparam int STRETCH_N = (stretch_cycles(CLK_HZ, STRETCH_MS) < 1) ? 1
                             : stretch_cycles(CLK_HZ, STRETCH_MS);
    localparam int N_EXT = 2;
    localparam int N_INT = 2;
    localparam int N_LED = 2;

    logic [N_SLOTS-1:0] slot_n_sync;
    logic [N_EXT-1:0]   ext_sync;
    logic [N_LED-1:0]   led_trig;
    logic [N_LED-1:0]   led_out;

    // Slot lines idle high, so reset the synchroniser to all ones
    busy_sync #(.W(N_SLOTS), .RST_VAL({N_SLOTS{1'b1}})) u_slot_sync (
        .clk(clk), .rst_n(rst_n), .d(slot_busy_n), .q(slot_n_sync)
    );

    busy_sync #(.W(N_EXT), .RST_VAL('0)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .d({ext_busy_ecl, ext_busy_nim}), .q(ext_sync)
    );

    assign status_slot_o = ~slot_n_sync;

    busy_merge #(.N_SLOTS(N_SLOTS), .N_EXT(N_EXT), .N_INT(N_INT)) u_merge (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_busy    (~slot_n_sync),
        .slot_mask    (slot_mask),
        .ext_busy     (ext_sync),
        .int_busy     ({int_burst, int_deadtime}),
        .test_busy    (test_busy),
        .en_slot      (en_slot),
        .en_ext       (en_ext),
        .en_int       (en_int),
        .standalone   (standalone),
        .busy_o       (busy_o),
        .status_src_o (status_src_o)
    );

    // Indicator channel 0: slot busy, channel 1: module busy
    assign led_trig = {busy_o, status_src_o[SRC_SLOT]};

    for (genvar g = 0; g < N_LED; g++) begin : g_led
        vis_stretch #(.N(STRETCH_N)) u_stretch (
            .clk(clk), .rst_n(rst_n), .trig(led_trig[g]), .led_o(led_out[g])
        );
    end

    assign led_slot_o   = led_out[0];
    assign led_module_o = led_out[1];
endmodule

// File: rtl/busy_checker.sv
// busy_checker: temporal properties of the crate busy combiner, bound
// to every instance of the top module.
module busy_checker
    import busy_pkg::*;
#(
    parameter int N_SLOTS = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_slot,
    input logic             en_ext,
    input logic             en_int,
    input logic             test_busy,
    input logic             standalone,
    input logic             busy_o,
    input logic [SRC_W-1:0] status_src_o,
    input logic             led_slot_o,
    input logic             led_module_o
);
    // R6: stand-alone mode forces busy on the next edge
    p_standalone_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        standalone |=> busy_o);

    // R3: with every term disabled and no forcing, busy stays low
    p_all_disabled_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_slot && !en_ext && !en_int && !standalone) |=> !busy_o);

    // R5: enabled test busy shows on the next edge
    p_test_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_int && test_busy) |=> busy_o);

    // R9: module indicator is on the cycle after busy
    p_led_module_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> led_module_o);

    // R10: slot indicator is on the cycle after slot busy status
    p_led_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        status_src_o[SRC_SLOT] |=> led_slot_o);
endmodule

bind crate_busy_combiner busy_checker #(.N_SLOTS(N_SLOTS)) u_busy_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_slot      (en_slot),
    .en_ext       (en_ext),
    .en_int       (en_int),
    .test_busy    (test_busy),
    .standalone   (standalone),
    .busy_o       (busy_o),
    .status_src_o (status_src_o),
    .led_slot_o   (led_slot_o),
    .led_module_o (led_module_o)
);

// File: tb/tb_crate_busy_combiner.sv
module tb_crate_busy_combiner;
    localparam int NS  = 16;
    localparam int NST = 10;   // 10 kHz, 1 ms -> 10 cycles

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0] slot_busy_n = '1;
    logic [NS-1:0] slot_mask = '0;
    logic en_slot = 0, en_ext = 0, en_int = 0;
    logic ext_busy_nim = 0, ext_busy_ecl = 0;
    logic int_deadtime = 0, int_burst = 0, test_busy = 0, standalone = 0;
    logic busy_o, led_slot_o, led_module_o;
    logic [NS-1:0] status_slot_o;
    logic [4:0] status_src_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    crate_busy_combiner #(.N_SLOTS(NS), .CLK_HZ(10_000), .STRETCH_MS(1)) dut (
        .clk(clk), .rst_n(rst_n), .slot_busy_n(slot_busy_n), .slot_mask(slot_mask),
        .en_slot(en_slot), .en_ext(en_ext), .en_int(en_int),
        .ext_busy_nim(ext_busy_nim), .ext_busy_ecl(ext_busy_ecl),
        .int_deadtime(int_deadtime), .int_burst(int_burst), .test_busy(test_busy),
        .standalone(standalone), .busy_o(busy_o), .status_slot_o(status_slot_o),
        .status_src_o(status_src_o), .led_slot_o(led_slot_o), .led_module_o(led_module_o)
    );

    // Reference: slot/ext seen two edges late, result registered (R7, R8)
    logic [NS-1:0] d1, d2;
    logic [1:0] e1, e2;
    logic exp_busy;
    logic [NS-1:0] exp_slot;
    logic [4:0] exp_src;

    function automatic logic [4:0] ref_src(input logic [NS-1:0] sn, input logic [1:0] ex);
        logic sa, ea, ia, b;
        sa = |(~sn & ~slot_mask);
        ea = |ex;
        ia = int_deadtime | int_burst;
        b  = (en_slot & sa) | (en_ext & ea) | (en_int & (ia | test_busy)) | standalone;
        return {b, test_busy, ia, ea, sa};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            d1 <= '1; d2 <= '1; e1 <= '0; e2 <= '0;
            exp_busy <= 0; exp_slot <= '0; exp_src <= '0;
        end else begin
            exp_src  <= ref_src(d2, e2);
            exp_busy <= ref_src(d2, e2)[4];
            exp_slot <= ~d1;
            d1 <= slot_busy_n; d2 <= d1;
            e1 <= {ext_busy_ecl, ext_busy_nim}; e2 <= e1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        slot_busy_n = '1; slot_mask = '0; en_slot = 0; en_ext = 0; en_int = 0;
        ext_busy_nim = 0; ext_busy_ecl = 0; int_deadtime = 0; int_burst = 0;
        test_busy = 0; standalone = 0;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int bcnt, lcnt;
        void'($urandom(32'd2718));
        waitn(3);
        // R11: reset state
        check("R11 busy_o", busy_o, 0);
        check("R11 status_slot", status_slot_o, 0);
        check("R11 status_src", status_src_o, 0);
        check("R11 leds", {led_slot_o, led_module_o}, 0);
        rst_n = 1;
        waitn(2);
        check("R11 busy_o after release", busy_o, 0);

        // R2: masked slots do not drive busy, status unaffected
        idle(); en_slot = 1; slot_busy_n = '0; slot_mask = '1;
        waitn(4);
        check("R2 busy_o masked", busy_o, 0);
        check("R2 status_slot unmasked", status_slot_o, 16'hFFFF);
        check("R2 status_src slot bit", status_src_o[0], 0);
        // R1: idle-high slots read not busy
        slot_mask = '0; slot_busy_n = '1;
        waitn(4);
        check("R1 busy_o empty slots", busy_o, 0);
        check("R1 status_slot", status_slot_o, 0);
        // R3: slot term gated by en_slot
        slot_busy_n = 16'hFFF7; en_slot = 0;
        waitn(4);
        check("R3 busy_o disabled", busy_o, 0);
        check("R1 status_slot bit3", status_slot_o, 16'h0008);
        en_slot = 1; waitn(1);
        check("R3 busy_o enabled", busy_o, 1);
        // R4: external term gated by en_ext
        idle(); ext_busy_ecl = 1; waitn(4);
        check("R4 busy_o disabled", busy_o, 0);
        check("R8 status_src ext bit", status_src_o, 5'b00010);
        en_ext = 1; waitn(1);
        check("R4 busy_o enabled", busy_o, 1);
        // R5: internal term gated by en_int
        idle(); int_burst = 1; waitn(4);
        check("R5 busy_o disabled", busy_o, 0);
        en_int = 1; waitn(1);
        check("R5 busy_o enabled", busy_o, 1);
        // R6: stand-alone forces busy
        idle(); waitn(4);
        standalone = 1; waitn(1);
        check("R6 busy_o forced", busy_o, 1);
        check("R8 status_src busy bit", status_src_o, 5'b10000);
        // R7: slot latency exactly three edges
        idle(); en_slot = 1; waitn(4);
        slot_busy_n = 16'hBFFF;
        waitn(1); check("R7 busy_o after 1 edge", busy_o, 0);
        waitn(1); check("R7 busy_o after 2 edges", busy_o, 0);
        waitn(1); check("R7 busy_o after 3 edges", busy_o, 1);
        // R7: internal path one edge
        idle(); waitn(4);
        en_int = 1; test_busy = 1; waitn(1);
        check("R7 busy_o test after 1 edge", busy_o, 1);

        // Random phase against the reference
        idle(); waitn(4);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            check("R7 busy_o random", busy_o, exp_busy);
            check("R1 R2 status_slot random", status_slot_o, exp_slot);
            check("R8 status_src random", status_src_o, exp_src);
            slot_busy_n  = NS'($urandom | $urandom | $urandom);
            if ($urandom_range(0, 7) == 0) slot_mask = NS'($urandom);
            en_slot      = 1'($urandom);
            en_ext       = 1'($urandom);
            en_int       = 1'($urandom);
            ext_busy_nim = ($urandom_range(0, 5) == 0);
            ext_busy_ecl = ($urandom_range(0, 5) == 0);
            int_deadtime = ($urandom_range(0, 5) == 0);
            int_burst    = ($urandom_range(0, 5) == 0);
            test_busy    = ($urandom_range(0, 7) == 0);
            standalone   = ($urandom_range(0, 15) == 0);
        end

        // R9: module indicator stretch length
        idle(); waitn(3 * NST);
        bcnt = 0; lcnt = 0; en_int = 1;
        for (int c = 0; c < 60; c++) begin
            test_busy = (c < 3);
            @(negedge clk);
            bcnt += busy_o; lcnt += led_module_o;
        end
        check("R9 busy cycles", bcnt, 3);
        check("R9 led_module cycles", lcnt, bcnt + NST - 1);
        // R10: slot indicator stretch length
        idle(); waitn(3 * NST);
        bcnt = 0; lcnt = 0;
        for (int c = 0; c < 60; c++) begin
            slot_busy_n = (c < 4) ? 16'hFFDF : 16'hFFFF;
            @(negedge clk);
            bcnt += status_src_o[0]; lcnt += led_slot_o;
        end
        check("R10 slot status cycles", bcnt, 4);
        check("R10 led_slot cycles", lcnt, bcnt + NST - 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule